// File: doc/BRIEF.md
# Multi-mode addressable bit latch

This block keeps a small bank of single-bit storage cells and lets a controller change one of them per clock through a binary index. One data bit, one index and two control levels are presented together. The controls pick one of four behaviours. The block can write the indexed bit and clear all others. It can write the indexed bit and leave the others alone. It can freeze the whole bank. It can clear the whole bank.

All storage is built from clocked registers. Every input is taken on the rising clock edge, and the outputs change only at that edge. An active-low reset clears the bank at once, whatever the controls show. The release of that reset is synchronised to the clock inside the block.

Typical uses are fanning a serial control stream out to individual enables, or driving a one-hot select. In both cases the bank stays frozen while upstream logic settles.

Top module: `addr_bit_latch`

## Requirements
- R1: Index value k selects output bit q[k] as the only write target; bit 0 corresponds to index 0.
- R2: With freeze=0 and retain=0 (demultiplex), after the edge q[index] equals din and every other output is 0.
- R3: With freeze=0 and retain=1 (addressed write), after the edge q[index] equals din and every other output keeps its previous value.
- R4: With freeze=1 and retain=1 (hold), an edge leaves all outputs unchanged, whatever the values of din and index.
- R5: With freeze=1 and retain=0 (clear), after the edge all outputs are 0.
- R6: When freeze rises from 0 to 1 while retain=1, each bit keeps the last value written before the rise.
- R7: Inputs are sampled only on the rising clock edge. Outputs do not move between edges, and a new control setting takes effect at the next edge.
- R8: rst_n low clears all outputs at once, whatever the mode. After rst_n rises just after a falling edge, the first write is taken at the third rising edge.
- R9: The output count N is a power of two of at least 2, and the index width is log2(N); the defaults are 8 outputs and a 3-bit index.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; every input is taken on its rising edge |
| rst_n | input | 1 | Asynchronous active-low reset; its release is synchronised inside the block |
| idx | input | AW (3) | Binary index of the target bit |
| din | input | 1 | Data bit written to the target |
| freeze | input | 1 | High blocks writes: the bank holds, or clears if retain is low |
| retain | input | 1 | High keeps the untargeted bits; low clears them |
| q | output | N (8) | Stored bits |

## Verification
The bench builds the block with its default eight outputs. At that size every mode, every index and both data values can be combined in one sweep. Before each operation the bank is loaded with a different background pattern through addressed writes, so that kept bits and cleared bits are told apart in both polarities. A mid-cycle asynchronous reset is also applied, and its synchronised release is counted edge by edge.

// File: rtl/abl_pkg.sv
package abl_pkg;
  typedef enum logic [1:0] {
    MODE_DEMUX = 2'b00,
    MODE_WRITE = 2'b01,
    MODE_CLEAR = 2'b10,
    MODE_HOLD  = 2'b11
  } abl_mode_e;
endpackage

// File: rtl/abl_rst_sync.sv
module abl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/abl_mode_dec.sv
module abl_mode_dec
  import abl_pkg::*;
(
  input  logic      freeze,
  input  logic      retain,
  output abl_mode_e mode
);
  always_comb begin
    unique case ({freeze, retain})
      2'b00:   mode = MODE_DEMUX;
      2'b01:   mode = MODE_WRITE;
      2'b10:   mode = MODE_CLEAR;
      default: mode = MODE_HOLD;
    endcase
  end
endmodule

// File: rtl/abl_addr_dec.sv
module abl_addr_dec #(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic [AW-1:0] idx,
  output logic [N-1:0]  sel
);
  for (genvar i = 0; i < N; i++) begin : g_sel
    assign sel[i] = (idx == AW'(i));
  end

  // R1: exactly one cell is targeted for any index
  always_comb begin
    p_sel_onehot_r1: assert ($countones(sel) == 1 || $isunknown(idx))
      else $error("R1: index decode not one-hot");
  end
endmodule

// File: rtl/abl_bit_cell.sv
module abl_bit_cell
  import abl_pkg::*;
(
  input  logic      clk,
  input  logic      rst_n,
  input  abl_mode_e mode,
  input  logic      sel,
  input  logic      din,
  output logic      q
);
  logic en;
  logic nxt;

  always_comb begin
    en  = 1'b1;
    nxt = 1'b0;
    unique case (mode)
      MODE_HOLD:  en = 1'b0;
      MODE_WRITE: begin en = sel; nxt = din; end
      MODE_DEMUX: nxt = sel & din;
      default:    nxt = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  q <= 1'b0;
    else if (en) q <= nxt;
  end
endmodule

// File: rtl/addr_bit_latch.sv
module addr_bit_latch
  import abl_pkg::*;
#(
  parameter int N  = 8,
  parameter int AW = $clog2(N)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [AW-1:0] idx,
  input  logic          din,
  input  logic          freeze,
  input  logic          retain,
  output logic [N-1:0]  q
);
  logic      core_rst_n;
  abl_mode_e mode;
  logic [N-1:0] sel;

  // R9: the output count must be a power of two
  initial begin
    p_pow2_r9: assert (N >= 2 && (N & (N - 1)) == 0 && (1 << AW) == N)
      else $error("R9: N must be a power of two and AW its log2");
  end

  abl_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  abl_mode_dec u_mode (
    .freeze (freeze),
    .retain (retain),
    .mode   (mode)
  );

  abl_addr_dec #(.N(N), .AW(AW)) u_addr (
    .idx (idx),
    .sel (sel)
  );

  for (genvar i = 0; i < N; i++) begin : g_cell
    abl_bit_cell u_cell (
      .clk   (clk),
      .rst_n (core_rst_n),
      .mode  (mode),
      .sel   (sel[i]),
      .din   (din),
      .q     (q[i])
    );
  end

  // R2: demultiplex clears the untargeted bits
  p_demux_others_r2: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!freeze && !retain) |=> ((q & ~$past(sel)) == '0))
    else $error("R2: untargeted bit set in demultiplex mode");

  // R1/R3: the indexed bit receives din when writing
  p_target_r1: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!freeze) |=> (q[$past(idx)] == $past(din)))
    else $error("R1: target bit does not hold written data");

  // R3: addressed write keeps the other bits
  p_write_keep_r3: assert property (@(posedge clk) disable iff (!core_rst_n)
    (!freeze && retain) |=> ((q & ~$past(sel)) == ($past(q) & ~$past(sel))))
    else $error("R3: untargeted bit changed in addressed write");

  // R4/R6: hold freezes the bank
  p_hold_stable_r4: assert property (@(posedge clk) disable iff (!core_rst_n)
    (freeze && retain) |=> $stable(q))
    else $error("R4: outputs moved in hold mode");

  // R5: clear empties the bank
  p_clear_r5: assert property (@(posedge clk) disable iff (!core_rst_n)
    (freeze && !retain) |=> (q == '0))
    else $error("R5: outputs not cleared");
endmodule

// File: tb/addr_bit_latch_test.sv
module addr_bit_latch_test;
  localparam int N  = 8;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n;
  logic [AW-1:0] idx;
  logic          din;
  logic          freeze;
  logic          retain;
  logic [N-1:0]  q;

  int tests  = 0;
  int fails  = 0;
  logic [N-1:0] model;
  bit done = 0;

  addr_bit_latch #(.N(N), .AW(AW)) uut (
    .clk(clk), .rst_n(rst_n), .idx(idx), .din(din),
    .freeze(freeze), .retain(retain), .q(q)
  );

  always #4 clk = ~clk;

  task automatic check(input string req, input logic [N-1:0] exp);
    tests++;
    if (q !== exp) begin
      fails++;
      $display("FAIL %s: q=%b expected %b", req, q, exp);
    end
  endtask

  function automatic logic [N-1:0] predict(input logic [N-1:0] cur, input logic fr,
                                           input logic rt, input int a, input logic d);
    logic [N-1:0] m;
    m = N'(1) << a;
    if (fr && rt)       return cur;
    else if (fr)        return '0;
    else if (rt)        return (cur & ~m) | (d ? m : '0);
    else                return d ? m : '0;
  endfunction

  // called at a falling edge; returns at the next falling edge
  task automatic apply(input string req, input logic fr, input logic rt,
                       input int a, input logic d);
    freeze = fr; retain = rt; idx = AW'(a); din = d;
    #1 check("R7", model);
    model = predict(model, fr, rt, a, d);
    @(negedge clk);
    check(req, model);
  endtask

  initial begin
    rst_n = 1'b0; freeze = 1'b1; retain = 1'b1; idx = '0; din = 1'b0;
    model = '0;
    repeat (3) @(negedge clk);
    check("R8", '0);
    rst_n = 1'b1;
    freeze = 1'b0; retain = 1'b1; idx = '0; din = 1'b1;
    @(negedge clk); check("R8", '0);
    @(negedge clk); check("R8", '0);
    @(negedge clk); check("R8", 8'h01);
    model = 8'h01;

    for (int mode = 0; mode < 4; mode++) begin
      for (int a = 0; a < N; a++) begin
        for (int d = 0; d < 2; d++) begin
          logic [N-1:0] bg;
          string req;
          bg = N'(8'hA5 ^ (a * 37) ^ (d * 8'h5A) ^ (mode * 8'h0F));
          for (int b = 0; b < N; b++) apply("R3", 1'b0, 1'b1, b, bg[b]);
          case (mode)
            0: req = "R2";
            1: req = "R3";
            2: req = "R5";
            default: req = "R4";
          endcase
          apply(req, mode[1], (mode == 1) || (mode == 3), a, d[0]);
          if (a == 0) apply("R1", 1'b0, 1'b1, N - 1, ~model[N-1]);
        end
      end
    end

    // R6: value written just before freeze rises is kept
    apply("R6", 1'b0, 1'b1, 5, 1'b1);
    apply("R6", 1'b0, 1'b1, 2, 1'b0);
    for (int k = 0; k < 4; k++) apply("R6", 1'b1, 1'b1, k * 2, k[0]);

    // R7: mode change takes effect only at the next edge
    apply("R7", 1'b1, 1'b0, 0, 1'b0);
    apply("R7", 1'b0, 1'b0, 6, 1'b1);

    // R8: asynchronous reset in mid-cycle, regardless of mode
    freeze = 1'b0; retain = 1'b1; idx = 3'd3; din = 1'b1;
    @(posedge clk); #2;
    rst_n = 1'b0;
    #1 check("R8", '0);
    @(negedge clk); rst_n = 1'b1; model = '0;
    @(negedge clk); check("R8", '0);
    @(negedge clk); check("R8", '0);
    @(negedge clk); check("R8", 8'h08);
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (20000) @(posedge clk);
        tests++; fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
      end
    join_any
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule